// File: doc/BRIEF.md
# Lockable Configuration Register Bank

This block holds two device-control registers reached through an index/data configuration port. The host writes an index byte, then reads or writes the data byte at that index. Index 0x00 carries a floppy-controller power enable and a software-only "valid" flag. Index 0x01 carries a parallel-port power enable, a printer/extended mode select and a lock bit. Once the lock bit is written to 0, the block refuses every data access in the configuration range until a reset.

Two resets act on the bank. The active-low asynchronous input resets everything. The synchronous hard-reset input changes only a few bits and leaves the rest alone. When the parallel-port power enable goes from 1 to 0, a sticky interrupt status output is raised. The power and mode levels leave the block as plain outputs. Powering a device down does not touch its address decoding, which lives outside this block.

Top module: `cfg_lock_bank`

## Requirements
- R1: After the asynchronous reset (rst_ni low), index 0x00 reads 0x20 and index 0x01 reads 0x98. The index register is 0x00, fdc_pwr_o and pp_pwr_o are 0, pp_printer_o is 1 and pint_o is 0.
- R2: Index 0x00 reads with bit 3 as the floppy power enable and bit 7 as the valid flag. Bit 5 always reads 1, and bits 0, 1, 2, 4 and 6 always read 0. A data write at this index loads only bits 7 and 3. fdc_pwr_o follows bit 3.
- R3: The valid flag (index 0x00 bit 7) can be written and read back. Changing it has no effect on any output other than rdata_o.
- R4: Index 0x01 reads with bit 7 as the lock, bit 3 as the mode select and bit 2 as the parallel-port power enable. Bit 4 always reads 1, and bits 0, 1, 5 and 6 always read 0. pp_printer_o follows bit 3 (1 = printer, 0 = extended modes) and pp_pwr_o follows bit 2.
- R5: A clock edge with hard_rst_i high clears the floppy power enable and the parallel-port power enable, and sets the lock bit to 1. The valid flag and the mode select keep their values. The hard reset takes priority over a data write in the same cycle.
- R6: Writing 0 to index 0x01 bit 7 locks the bank. From the next cycle on, data reads at indices 0x00 to 0x39 return 0x00 and data writes there change nothing. Writing 1 to the lock bit cannot unlock the bank. Only a hard reset or the asynchronous reset can.
- R7: The index register and data accesses work only while cfg_mode_i is 1. With cfg_mode_i low, rdata_o is 0x00, and index writes and data writes are ignored.
- R8: Data reads at any index other than 0x00 and 0x01 return 0x00, and data writes there change no register.
- R9: pint_o goes to 1 on the same clock edge on which pp_pwr_o falls from 1 to 0, whether a write or a hard reset caused the fall. It stays at 1 until a cycle with pint_clr_i high and no new fall; a fall and a clear in the same cycle leave it at 1. The asynchronous reset clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| hard_rst_i | input | 1 | Synchronous hard reset, active high |
| cfg_mode_i | input | 1 | High while the port is in the configuration state |
| idx_we_i | input | 1 | Loads wdata_i into the index register |
| data_we_i | input | 1 | Writes wdata_i to the register selected by the index |
| wdata_i | input | 8 | Index or data byte |
| pint_clr_i | input | 1 | Write-1-to-clear strobe for pint_o |
| rdata_o | output | 8 | Data byte of the selected register, 0x00 when access is refused |
| fdc_pwr_o | output | 1 | Floppy-controller power enable |
| pp_pwr_o | output | 1 | Parallel-port power enable |
| pp_printer_o | output | 1 | 1 = printer mode, 0 = extended modes |
| pint_o | output | 1 | Sticky parallel-port power-down interrupt status |

## Verification
The bench checks the lock's stickiness. After locking, it writes 1 to the lock bit and checks that the mode output does not move. A design that let a locked write through would change the mode output or read back a nonzero value. It runs a hard reset with a data write in the same cycle, and checks that the power bits clear while the valid flag and the mode select are kept. A design with the wrong priority, or that reused the power-on defaults, would show a different read-back. It also raises a power fall and a clear strobe in the same cycle, where a design that let the clear win would drop pint_o. Finally, it checks that a refused access gives 0x00 and not the fixed reserved pattern.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;
  localparam int unsigned DATA_W = 8;
  typedef logic [DATA_W-1:0] cfg_byte_t;

  // bit positions decoded by software
  localparam int unsigned R0_VALID_BIT = 7;
  localparam int unsigned R0_FDC_BIT   = 3;
  localparam int unsigned R1_LOCK_BIT  = 7;
  localparam int unsigned R1_MODE_BIT  = 3;
  localparam int unsigned R1_PP_BIT    = 2;

  // constant read-back of reserved bits
  localparam cfg_byte_t R0_FIXED = 8'h20;
  localparam cfg_byte_t R1_FIXED = 8'h10;

  typedef struct packed {
    logic valid;
    logic fdc_pwr;
  } dev0_t;

  typedef struct packed {
    logic lock;
    logic printer;
    logic pp_pwr;
  } dev1_t;

  localparam dev0_t DEV0_POR = '{valid: 1'b0, fdc_pwr: 1'b0};
  localparam dev1_t DEV1_POR = '{lock: 1'b1, printer: 1'b1, pp_pwr: 1'b0};
endpackage

// File: rtl/cfg_index_port.sv
module cfg_index_port #(
  parameter int unsigned IDX_W    = 8,
  parameter logic [IDX_W-1:0] LAST_IDX = IDX_W'(8'h39)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_mode_i,
  input  logic             idx_we_i,
  input  logic [IDX_W-1:0] idx_wdata_i,
  input  logic             unlocked_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             sel0_o,
  output logic             sel1_o
);
  localparam logic [IDX_W-1:0] IDX_R0 = '0;
  localparam logic [IDX_W-1:0] IDX_R1 = IDX_W'(1);

  logic [IDX_W-1:0] idx_q;
  logic             in_range;
  logic             acc_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     idx_q <= '0;
    else if (cfg_mode_i && idx_we_i) idx_q <= idx_wdata_i;
  end

  always_comb begin
    in_range = (idx_q <= LAST_IDX);
    acc_en   = cfg_mode_i && unlocked_i && in_range;
    sel0_o   = acc_en && (idx_q == IDX_R0);
    sel1_o   = acc_en && (idx_q == IDX_R1);
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/cfg_dev_regs.sv
module cfg_dev_regs
  import cfg_lock_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  hard_rst_i,
  input  logic  wr0_i,
  input  logic  wr1_i,
  input  dev0_t w0_i,
  input  dev1_t w1_i,
  output dev0_t r0_o,
  output dev1_t r1_o,
  output logic  pp_fall_o
);
  dev0_t r0_q, r0_d;
  dev1_t r1_q, r1_d;

  always_comb begin
    r0_d = r0_q;
    r1_d = r1_q;
    if (hard_rst_i) begin
      r0_d.fdc_pwr = 1'b0;
      r1_d.lock    = 1'b1;
      r1_d.pp_pwr  = 1'b0;
    end else begin
      if (wr0_i) r0_d = w0_i;
      if (wr1_i) begin
        r1_d.lock    = r1_q.lock & w1_i.lock; // can only drop
        r1_d.printer = w1_i.printer;
        r1_d.pp_pwr  = w1_i.pp_pwr;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r0_q <= DEV0_POR;
      r1_q <= DEV1_POR;
    end else begin
      r0_q <= r0_d;
      r1_q <= r1_d;
    end
  end

  assign r0_o      = r0_q;
  assign r1_o      = r1_q;
  assign pp_fall_o = r1_q.pp_pwr & ~r1_d.pp_pwr;
endmodule

// File: rtl/cfg_pint.sv
module cfg_pint (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pint_o
);
  logic pint_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pint_q <= 1'b0;
    else if (set_i)  pint_q <= 1'b1;
    else if (clr_i)  pint_q <= 1'b0;
  end

  assign pint_o = pint_q;
endmodule

// File: rtl/cfg_lock_bank.sv
module cfg_lock_bank
  import cfg_lock_pkg::*;
#(
  parameter int unsigned IDX_W    = 8,
  parameter logic [IDX_W-1:0] LAST_IDX = IDX_W'(8'h39)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hard_rst_i,
  input  logic       cfg_mode_i,
  input  logic       idx_we_i,
  input  logic       data_we_i,
  input  logic [7:0] wdata_i,
  input  logic       pint_clr_i,
  output logic [7:0] rdata_o,
  output logic       fdc_pwr_o,
  output logic       pp_pwr_o,
  output logic       pp_printer_o,
  output logic       pint_o
);
  logic [IDX_W-1:0] idx_q;
  logic             sel0, sel1;
  logic             lock_q;
  logic             pp_fall;
  dev0_t            r0, w0;
  dev1_t            r1, w1;

  cfg_index_port #(.IDX_W(IDX_W), .LAST_IDX(LAST_IDX)) u_idx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_mode_i  (cfg_mode_i),
    .idx_we_i    (idx_we_i),
    .idx_wdata_i (wdata_i[IDX_W-1:0]),
    .unlocked_i  (lock_q),
    .idx_o       (idx_q),
    .sel0_o      (sel0),
    .sel1_o      (sel1)
  );

  always_comb begin
    w0.valid   = wdata_i[R0_VALID_BIT];
    w0.fdc_pwr = wdata_i[R0_FDC_BIT];
    w1.lock    = wdata_i[R1_LOCK_BIT];
    w1.printer = wdata_i[R1_MODE_BIT];
    w1.pp_pwr  = wdata_i[R1_PP_BIT];
  end

  cfg_dev_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hard_rst_i (hard_rst_i),
    .wr0_i      (data_we_i && sel0),
    .wr1_i      (data_we_i && sel1),
    .w0_i       (w0),
    .w1_i       (w1),
    .r0_o       (r0),
    .r1_o       (r1),
    .pp_fall_o  (pp_fall)
  );

  cfg_pint u_pint (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (pp_fall),
    .clr_i  (pint_clr_i),
    .pint_o (pint_o)
  );

  assign lock_q = r1.lock;

  always_comb begin
    rdata_o = '0;
    if (sel0) begin
      rdata_o               = R0_FIXED;
      rdata_o[R0_VALID_BIT] = r0.valid;
      rdata_o[R0_FDC_BIT]   = r0.fdc_pwr;
    end else if (sel1) begin
      rdata_o               = R1_FIXED;
      rdata_o[R1_LOCK_BIT]  = r1.lock;
      rdata_o[R1_MODE_BIT]  = r1.printer;
      rdata_o[R1_PP_BIT]    = r1.pp_pwr;
    end
  end

  assign fdc_pwr_o    = r0.fdc_pwr;
  assign pp_pwr_o     = r1.pp_pwr;
  assign pp_printer_o = r1.printer;
endmodule

// File: rtl/cfg_lock_bank_chk.sv
module cfg_lock_bank_chk #(
  parameter int unsigned IDX_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hard_rst_i,
  input logic             cfg_mode_i,
  input logic             pint_clr_i,
  input logic [7:0]       rdata_o,
  input logic             fdc_pwr_o,
  input logic             pp_pwr_o,
  input logic             pint_o,
  input logic             lock_q,
  input logic [IDX_W-1:0] idx_q
);
  // R2
  reserved0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_i && lock_q && idx_q == '0) |-> ((rdata_o & 8'h77) == 8'h20));

  // R4
  reserved1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_mode_i && lock_q && idx_q == IDX_W'(1)) |-> ((rdata_o & 8'h73) == 8'h10));

  // R5
  hard_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_rst_i |=> (lock_q && !fdc_pwr_o && !pp_pwr_o));

  // R6
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lock_q && !hard_rst_i) |=> !lock_q);

  // R6
  locked_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |-> (rdata_o == 8'h00));

  // R7
  cfg_off_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_mode_i |-> (rdata_o == 8'h00));

  // R8
  other_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q > IDX_W'(1)) |-> (rdata_o == 8'h00));

  // R9
  pint_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pp_pwr_o) |-> pint_o);

  // R9
  pint_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pint_o && !pint_clr_i) |=> pint_o);
endmodule

bind cfg_lock_bank cfg_lock_bank_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .hard_rst_i (hard_rst_i),
  .cfg_mode_i (cfg_mode_i),
  .pint_clr_i (pint_clr_i),
  .rdata_o    (rdata_o),
  .fdc_pwr_o  (fdc_pwr_o),
  .pp_pwr_o   (pp_pwr_o),
  .pint_o     (pint_o),
  .lock_q     (lock_q),
  .idx_q      (idx_q)
);

// File: tb/cfg_lock_bank_bench.sv
module cfg_lock_bank_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hard_rst_i = 1'b0;
  logic       cfg_mode_i = 1'b1;
  logic       idx_we_i = 1'b0;
  logic       data_we_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic       pint_clr_i = 1'b0;
  logic [7:0] rdata_o;
  logic       fdc_pwr_o, pp_pwr_o, pp_printer_o, pint_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  cfg_lock_bank u_cfg_lock_bank (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hard_rst_i   (hard_rst_i),
    .cfg_mode_i   (cfg_mode_i),
    .idx_we_i     (idx_we_i),
    .data_we_i    (data_we_i),
    .wdata_i      (wdata_i),
    .pint_clr_i   (pint_clr_i),
    .rdata_o      (rdata_o),
    .fdc_pwr_o    (fdc_pwr_o),
    .pp_pwr_o     (pp_pwr_o),
    .pp_printer_o (pp_printer_o),
    .pint_o       (pint_o)
  );

  typedef struct packed {
    logic [7:0] idx;
    logic [7:0] wd;
    logic [7:0] exp;
  } vec_t;

  // R2 R4 R8 write/read-back vectors
  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{8'h00, 8'hFF, 8'hA8},
    '{8'h00, 8'h00, 8'h20},
    '{8'h00, 8'h88, 8'hA8},
    '{8'h00, 8'h77, 8'h20},
    '{8'h01, 8'h8C, 8'h9C},
    '{8'h01, 8'h80, 8'h90},
    '{8'h01, 8'hF3, 8'h90},
    '{8'h05, 8'hFF, 8'h00},
    '{8'h39, 8'h12, 8'h00},
    '{8'h01, 8'h88, 8'h98}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic set_idx(input logic [7:0] i);
    @(negedge clk_i);
    idx_we_i = 1'b1;
    wdata_i  = i;
    @(negedge clk_i);
    idx_we_i = 1'b0;
  endtask

  task automatic wr_data(input logic [7:0] d, input logic clr);
    @(negedge clk_i);
    data_we_i  = 1'b1;
    wdata_i    = d;
    pint_clr_i = clr;
    @(negedge clk_i);
    data_we_i  = 1'b0;
    pint_clr_i = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk_i);
    pint_clr_i = 1'b1;
    @(negedge clk_i);
    pint_clr_i = 1'b0;
  endtask

  task automatic pulse_hard(input logic with_wr, input logic [7:0] d);
    @(negedge clk_i);
    hard_rst_i = 1'b1;
    data_we_i  = with_wr;
    wdata_i    = d;
    @(negedge clk_i);
    hard_rst_i = 1'b0;
    data_we_i  = 1'b0;
  endtask

  task automatic por();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 power-on state
    chk("R1 rdata idx0", rdata_o, 8'h20);
    chk("R1 fdc_pwr", {7'd0, fdc_pwr_o}, 8'h00);
    chk("R1 pp_pwr", {7'd0, pp_pwr_o}, 8'h00);
    chk("R1 printer", {7'd0, pp_printer_o}, 8'h01);
    chk("R1 pint", {7'd0, pint_o}, 8'h00);
    set_idx(8'h01);
    chk("R1 rdata idx1", rdata_o, 8'h98);

    // R2 R4 R8 vector walk
    for (int k = 0; k < NVEC; k++) begin
      set_idx(VECS[k].idx);
      wr_data(VECS[k].wd, 1'b0);
      chk($sformatf("R2/R4/R8 vec%0d", k), rdata_o, VECS[k].exp);
    end
    set_idx(8'h00);
    chk("R8 idx0 untouched by others", rdata_o, 8'h20);

    // R3 valid flag has no side effect
    wr_data(8'h80, 1'b0);
    chk("R3 valid readback", rdata_o, 8'hA0);
    chk("R3 fdc_pwr unchanged", {7'd0, fdc_pwr_o}, 8'h00);
    chk("R3 pp_pwr unchanged", {7'd0, pp_pwr_o}, 8'h00);
    chk("R3 printer unchanged", {7'd0, pp_printer_o}, 8'h01);
    wr_data(8'h08, 1'b0);
    chk("R2 fdc_pwr follows bit3", {7'd0, fdc_pwr_o}, 8'h01);

    // R9 interrupt
    pulse_clr();
    chk("R9 clear", {7'd0, pint_o}, 8'h00);
    set_idx(8'h01);
    wr_data(8'h8C, 1'b0);
    chk("R4 pp_pwr on", {7'd0, pp_pwr_o}, 8'h01);
    chk("R9 no set on rise", {7'd0, pint_o}, 8'h00);
    wr_data(8'h88, 1'b0);
    chk("R9 set on fall", {7'd0, pint_o}, 8'h01);
    wr_data(8'h8C, 1'b1);
    chk("R9 clear on rise", {7'd0, pint_o}, 8'h00);
    wr_data(8'h88, 1'b1);
    chk("R9 set wins over clear", {7'd0, pint_o}, 8'h01);
    pulse_clr();
    chk("R9 cleared", {7'd0, pint_o}, 8'h00);

    // R5 hard reset with concurrent write
    set_idx(8'h00);
    wr_data(8'h88, 1'b0);
    set_idx(8'h01);
    wr_data(8'h84, 1'b0);
    chk("R4 extended mode", {7'd0, pp_printer_o}, 8'h00);
    set_idx(8'h00);
    pulse_hard(1'b1, 8'h08);
    chk("R5 fdc_pwr cleared", {7'd0, fdc_pwr_o}, 8'h00);
    chk("R5 pp_pwr cleared", {7'd0, pp_pwr_o}, 8'h00);
    chk("R5 printer kept", {7'd0, pp_printer_o}, 8'h00);
    chk("R9 set by hard reset", {7'd0, pint_o}, 8'h01);
    chk("R5 idx0 valid kept", rdata_o, 8'hA0);
    set_idx(8'h01);
    chk("R5 idx1", rdata_o, 8'h90);

    // R7 outside configuration state
    @(negedge clk_i);
    cfg_mode_i = 1'b0;
    @(negedge clk_i);
    chk("R7 read zero", rdata_o, 8'h00);
    wr_data(8'h8C, 1'b0);
    chk("R7 write ignored", {7'd0, pp_pwr_o}, 8'h00);
    set_idx(8'h00);
    @(negedge clk_i);
    cfg_mode_i = 1'b1;
    @(negedge clk_i);
    chk("R7 index write ignored", rdata_o, 8'h90);

    // R6 lock
    wr_data(8'h04, 1'b0);
    chk("R6 locking write applies", {7'd0, pp_pwr_o}, 8'h01);
    chk("R6 idx1 reads zero", rdata_o, 8'h00);
    set_idx(8'h00);
    chk("R6 idx0 reads zero", rdata_o, 8'h00);
    wr_data(8'h08, 1'b0);
    chk("R6 idx0 write blocked", {7'd0, fdc_pwr_o}, 8'h00);
    set_idx(8'h01);
    wr_data(8'h8C, 1'b0);
    chk("R6 unlock write blocked", {7'd0, pp_printer_o}, 8'h00);
    chk("R6 still locked", rdata_o, 8'h00);
    pulse_hard(1'b0, 8'h00);
    chk("R6 hard reset unlocks", rdata_o, 8'h90);
    wr_data(8'h0C, 1'b0);
    chk("R6 relocked", rdata_o, 8'h00);
    por();
    chk("R1 por idx0", rdata_o, 8'h20);
    chk("R1 por pint", {7'd0, pint_o}, 8'h00);
    set_idx(8'h01);
    chk("R6 por unlocks", rdata_o, 8'h98);

    done = 1'b1;
    finish_run();
  end
endmodule